// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block generates the conversion timing for a delta-sigma converter. It runs on a clock at twice the modulator clock. Every delay is therefore counted in half-periods of the modulator clock (one tick each), and the 28.5-period startup delay is exactly 57 ticks. A one-cycle start request, already aligned to the moment the command byte is latched, starts a new sequence. The block first waits out the startup delay. It then counts one conversion whose length depends on the mode and on a 2-bit rate code. At the end of each conversion it pulls its active-low ready output down and pulses a done strobe.

The rate codes are 0, 1, 2 and 3, for the 20, 90, 330 and 1000 samples-per-second settings. In single-shot mode a conversion lasts 51213, 11557, 3141 or 1061 modulator periods. Once it completes, the ready output stays low until the next start. In continuous mode a conversion lasts 51192, 11532, 3116 or 1036 periods, and conversions repeat back to back without a new startup delay. In this mode the ready output goes high again one modulator period before each following completion.

The sequencer has four states. ST_IDLE is the state after reset, with ready high. ST_STARTUP counts the 57-tick delay. ST_CONVERT counts one conversion. ST_HOLD follows a single-shot completion, with ready low. The transitions are:
- start (from any state) to ST_STARTUP.
- startup-expired from ST_STARTUP to ST_CONVERT.
- continuous-complete from ST_CONVERT back to ST_CONVERT, with the conversion count reloaded.
- single-complete from ST_CONVERT to ST_HOLD.

Reset returns the block to ST_IDLE.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, drdy_n_o is 1 and done_o is 0, and both stay so until a start is accepted.
- R2: In the cycle after start_i is sampled high, drdy_n_o is 1 and done_o is 0, whatever the previous state.
- R3: With cont_i=0 sampled at start, drdy_n_o falls exactly 57 + 2*S cycles after the clock edge that samples start_i. S is 51213, 11557, 3141 or 1061 for rate_i codes 0, 1, 2 and 3.
- R4: With cont_i=1 sampled at start, the first fall of drdy_n_o comes exactly 57 + 2*C cycles after the sampling edge. C is 51192, 11532, 3116 or 1036 for rate_i codes 0, 1, 2 and 3.
- R5: In continuous mode each later fall of drdy_n_o comes exactly 2*C cycles after the previous one.
- R6: In continuous mode drdy_n_o returns to 1 exactly 2 cycles before each later fall.
- R7: After a single-shot completion, drdy_n_o stays 0 and no further done_o pulse appears until the next start.
- R8: done_o is a one-cycle pulse. It is high exactly in the first cycle that drdy_n_o is 0 after a conversion completes.
- R9: A start accepted during startup or during a conversion aborts that sequence. No completion from the aborted sequence appears, and timing restarts in full from the new start.
- R10: rate_i and cont_i are sampled only in the cycle start_i is accepted. Changing them at any other time has no effect on the running sequence.
- R11: cont_i=1 selects continuous operation and cont_i=0 selects single-shot operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start/sync request, one cycle, aligned to command latch |
| cont_i | input | 1 | Mode select: 1 continuous, 0 single-shot |
| rate_i | input | 2 | Data-rate code: 0=20, 1=90, 2=330, 3=1000 SPS |
| drdy_n_o | output | 1 | Active-low data ready, falls at each completion |
| done_o | output | 1 | One-cycle strobe at each completion |

## Verification
The assertions assume that start_i, cont_i and rate_i are synchronous to clk and change only away from its rising edge. They also assume that a start request may arrive in any state and at any point of a conversion. The period check applies only to two completions in a row with no start between them, so it tolerates aborts. The stimulus drives every input on the falling clock edge and gives each start as a single-cycle pulse. It changes mode and rate in the middle of conversions, and it places aborting starts both inside the startup delay and deep inside a continuous conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned RATE_W    = 2;
    localparam int unsigned NUM_RATES = 1 << RATE_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STARTUP = 2'd1,
        ST_CONVERT = 2'd2,
        ST_HOLD    = 2'd3
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_rate_lut.sv
module adc_seq_rate_lut
    import adc_seq_pkg::*;
#(
    parameter int unsigned CNT_W       = 17,
    parameter int unsigned SS_TCLK_0   = 51213,
    parameter int unsigned SS_TCLK_1   = 11557,
    parameter int unsigned SS_TCLK_2   = 3141,
    parameter int unsigned SS_TCLK_3   = 1061,
    parameter int unsigned CONT_TCLK_0 = 51192,
    parameter int unsigned CONT_TCLK_1 = 11532,
    parameter int unsigned CONT_TCLK_2 = 3116,
    parameter int unsigned CONT_TCLK_3 = 1036
) (
    input  logic [RATE_W-1:0] rate_i,
    input  logic              cont_i,
    output logic [CNT_W-1:0]  load_o
);

    localparam int unsigned SS_TAB   [NUM_RATES] = '{SS_TCLK_0, SS_TCLK_1, SS_TCLK_2, SS_TCLK_3};
    localparam int unsigned CONT_TAB [NUM_RATES] = '{CONT_TCLK_0, CONT_TCLK_1, CONT_TCLK_2, CONT_TCLK_3};

    logic [CNT_W-1:0] ss_load   [NUM_RATES];
    logic [CNT_W-1:0] cont_load [NUM_RATES];

    // Down-counter load is ticks-minus-one; one tick is half a modulator period.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign ss_load[g]   = CNT_W'(2 * SS_TAB[g] - 1);
        assign cont_load[g] = CNT_W'(2 * CONT_TAB[g] - 1);
    end

    always_comb begin
        if (cont_i) begin
            load_o = cont_load[rate_i];
        end else begin
            load_o = ss_load[rate_i];
        end
    end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o,
    output logic             two_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
    assign two_o  = (cnt_q == CNT_W'(2));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned CNT_W      = 17,
    parameter int unsigned START_HALF = 57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [CNT_W-1:0]  conv_load_i,
    input  logic              cnt_zero_i,
    input  logic              cnt_two_i,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              cont_q_o,
    output logic [RATE_W-1:0] rate_q_o,
    output logic              drdy_n_o,
    output logic              done_o
);

    localparam logic [CNT_W-1:0] START_LOAD = CNT_W'(START_HALF - 1);

    seq_state_e st_q, st_d;
    logic       mark_hi, mark_lo;
    logic       drdy_n_q, done_q;

    // Next-state and counter-load decisions; a start wins over everything.
    always_comb begin
        st_d       = st_q;
        load_o     = 1'b0;
        load_val_o = conv_load_i;
        mark_hi    = 1'b0;
        mark_lo    = 1'b0;
        if (start_i) begin
            st_d       = ST_STARTUP;
            load_o     = 1'b1;
            load_val_o = START_LOAD;
            mark_hi    = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d = ST_IDLE;
                end
                ST_STARTUP: begin
                    if (cnt_zero_i) begin
                        st_d   = ST_CONVERT;
                        load_o = 1'b1;
                    end
                end
                ST_CONVERT: begin
                    if (cnt_zero_i) begin
                        mark_lo = 1'b1;
                        if (cont_q_o) begin
                            st_d   = ST_CONVERT;
                            load_o = 1'b1;
                        end else begin
                            st_d = ST_HOLD;
                        end
                    end else if (cnt_two_i) begin
                        mark_hi = 1'b1;
                    end
                end
                ST_HOLD: begin
                    st_d = ST_HOLD;
                end
                default: begin
                    st_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register, with mode and rate captured only on an accepted start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cont_q_o <= 1'b0;
            rate_q_o <= '0;
        end else begin
            st_q <= st_d;
            if (start_i) begin
                cont_q_o <= cont_i;
                rate_q_o <= rate_i;
            end
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_n_q <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= mark_lo;
            if (mark_hi) begin
                drdy_n_q <= 1'b1;
            end else if (mark_lo) begin
                drdy_n_q <= 1'b0;
            end
        end
    end

    assign drdy_n_o = drdy_n_q;
    assign done_o   = done_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned START_HALF  = 57,
    parameter int unsigned SS_TCLK_0   = 51213,
    parameter int unsigned SS_TCLK_1   = 11557,
    parameter int unsigned SS_TCLK_2   = 3141,
    parameter int unsigned SS_TCLK_3   = 1061,
    parameter int unsigned CONT_TCLK_0 = 51192,
    parameter int unsigned CONT_TCLK_1 = 11532,
    parameter int unsigned CONT_TCLK_2 = 3116,
    parameter int unsigned CONT_TCLK_3 = 1036
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              drdy_n_o,
    output logic              done_o
);

    localparam int unsigned MAX_SS   = max2(max2(SS_TCLK_0, SS_TCLK_1), max2(SS_TCLK_2, SS_TCLK_3));
    localparam int unsigned MAX_CONT = max2(max2(CONT_TCLK_0, CONT_TCLK_1), max2(CONT_TCLK_2, CONT_TCLK_3));
    localparam int unsigned MAX_TICK = max2(2 * max2(MAX_SS, MAX_CONT), START_HALF);
    localparam int unsigned CNT_W    = $clog2(MAX_TICK + 1);

    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  conv_load;
    logic              cnt_zero;
    logic              cnt_two;
    logic              cont_q;
    logic [RATE_W-1:0] rate_q;

    adc_seq_rate_lut #(
        .CNT_W       (CNT_W),
        .SS_TCLK_0   (SS_TCLK_0),
        .SS_TCLK_1   (SS_TCLK_1),
        .SS_TCLK_2   (SS_TCLK_2),
        .SS_TCLK_3   (SS_TCLK_3),
        .CONT_TCLK_0 (CONT_TCLK_0),
        .CONT_TCLK_1 (CONT_TCLK_1),
        .CONT_TCLK_2 (CONT_TCLK_2),
        .CONT_TCLK_3 (CONT_TCLK_3)
    ) u_lut (
        .rate_i (rate_q),
        .cont_i (cont_q),
        .load_o (conv_load)
    );

    adc_seq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .zero_o     (cnt_zero),
        .two_o      (cnt_two)
    );

    adc_seq_fsm #(
        .CNT_W      (CNT_W),
        .START_HALF (START_HALF)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cont_i      (cont_i),
        .rate_i      (rate_i),
        .conv_load_i (conv_load),
        .cnt_zero_i  (cnt_zero),
        .cnt_two_i   (cnt_two),
        .load_o      (load),
        .load_val_o  (load_val),
        .cont_q_o    (cont_q),
        .rate_q_o    (rate_q),
        .drdy_n_o    (drdy_n_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/adc_conv_seq_checker.sv
module adc_conv_seq_checker
    import adc_seq_pkg::*;
#(
    parameter int unsigned CONT_TCLK_0 = 51192,
    parameter int unsigned CONT_TCLK_1 = 11532,
    parameter int unsigned CONT_TCLK_2 = 3116,
    parameter int unsigned CONT_TCLK_3 = 1036
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              cont_q,
    input logic [RATE_W-1:0] rate_q,
    input logic              drdy_n_o,
    input logic              done_o
);

    localparam int unsigned CONT_TAB [NUM_RATES] = '{CONT_TCLK_0, CONT_TCLK_1, CONT_TCLK_2, CONT_TCLK_3};

    logic [31:0] gap_q;
    logic        seen_q;

    // Cycles since the last completion; cleared by a start so aborts are excluded.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 32'd1;
            seen_q <= 1'b0;
        end else if (start_i) begin
            gap_q  <= 32'd1;
            seen_q <= 1'b0;
        end else if (done_o) begin
            gap_q  <= 32'd1;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 32'd1;
        end
    end

    // R8: done coincides with the falling edge of ready
    a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!drdy_n_o && $past(drdy_n_o)));

    // R8: ready never falls without done
    a_r8_fall_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n_o) |-> done_o);

    // R2: start raises ready and suppresses done in the next cycle
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (drdy_n_o && !done_o));

    // R7: single-shot ready stays low until the next start
    a_r7_ss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n_o && !cont_q && !start_i) |=> !drdy_n_o);

    // R5: continuous completions are spaced by the conversion length
    a_r5_cont_period: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && seen_q && cont_q) |-> (gap_q == 32'(2 * CONT_TAB[rate_q])));

endmodule

bind adc_conv_seq adc_conv_seq_checker #(
    .CONT_TCLK_0 (CONT_TCLK_0),
    .CONT_TCLK_1 (CONT_TCLK_1),
    .CONT_TCLK_2 (CONT_TCLK_2),
    .CONT_TCLK_3 (CONT_TCLK_3)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cont_q   (cont_q),
    .rate_q   (rate_q),
    .drdy_n_o (drdy_n_o),
    .done_o   (done_o)
);

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;

    localparam int unsigned START_HALF = 57;
    localparam int unsigned SS   [4] = '{51213, 11557, 3141, 1061};
    localparam int unsigned CONT [4] = '{51192, 11532, 3116, 1036};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cont_i = 1'b0;
    logic [1:0] rate_i = 2'd0;
    logic       drdy_n_o;
    logic       done_o;

    always #10 clk = ~clk;

    adc_conv_seq u_adc_conv_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cont_i   (cont_i),
        .rate_i   (rate_i),
        .drdy_n_o (drdy_n_o),
        .done_o   (done_o)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned t;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected completion cycles and compares.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done at cycle", int'(cyc), 0);
                end else begin
                    cur = exp_q.pop_front();
                    check(cyc == cur.t, cur.req, "done cycle", int'(cyc), int'(cur.t));
                    check(drdy_n_o == 1'b0, "R8", "drdy_n with done", int'(drdy_n_o), 0);
                end
            end else if (exp_q.size() != 0 && cyc > exp_q[0].t) begin
                cur = exp_q.pop_front();
                check(1'b0, cur.req, "missing done by cycle", int'(cyc), int'(cur.t));
            end
        end
    end

    // Driver: called at a falling edge; pushes the expected completions.
    task automatic issue_start(input bit cont, input int rate, input int nconv,
                               input string req, output int unsigned first_t);
        int unsigned n;
        exp_t e;
        n = cont ? CONT[rate] : SS[rate];
        exp_q.delete();
        start_i = 1'b1;
        cont_i  = cont;
        rate_i  = rate[1:0];
        first_t = cyc + 1 + START_HALF + 2 * n;
        for (int i = 0; i < nconv; i++) begin
            e.t   = first_t + i * 2 * n;
            e.req = (i == 0) ? req : "R5";
            exp_q.push_back(e);
        end
        @(negedge clk);
        start_i = 1'b0;
        check(drdy_n_o == 1'b1 && done_o == 1'b0, "R2", "drdy_n after start",
              int'(drdy_n_o), 1);
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic wait_cyc(input int unsigned x);
        while (cyc < x) @(negedge clk);
    endtask

    initial begin
        int unsigned t;
        repeat (4) @(negedge clk);
        check(drdy_n_o == 1'b1, "R1", "drdy_n in reset", int'(drdy_n_o), 1);
        check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check(drdy_n_o == 1'b1 && done_o == 1'b0, "R1", "idle after reset", int'(drdy_n_o), 1);

        // Single-shot, fastest rate; inputs changed mid-conversion (R10)
        issue_start(1'b0, 3, 1, "R3/R11", t);
        cont_i = 1'b1;
        rate_i = 2'd0;
        wait_empty();
        check(drdy_n_o == 1'b0, "R3", "drdy_n after single done", int'(drdy_n_o), 0);
        wait_cyc(t + 2 * SS[3] + 200);
        check(drdy_n_o == 1'b0, "R7", "drdy_n held after single", int'(drdy_n_o), 0);
        check(exp_q.size() == 0, "R10", "pending items", exp_q.size(), 0);

        // Other single-shot rates (start from a low ready exercises R2)
        issue_start(1'b0, 2, 1, "R3", t);
        wait_empty();
        issue_start(1'b0, 1, 1, "R3", t);
        wait_empty();
        issue_start(1'b0, 0, 1, "R3", t);
        wait_empty();

        // Continuous, fastest rate, three completions
        issue_start(1'b1, 3, 3, "R4 R11", t);
        cont_i = 1'b0;
        rate_i = 2'd1;
        wait_cyc(t + 2 * CONT[3] - 3);
        check(drdy_n_o == 1'b0, "R6", "drdy_n three before second", int'(drdy_n_o), 0);
        @(negedge clk);
        check(drdy_n_o == 1'b1, "R6", "drdy_n two before second", int'(drdy_n_o), 1);
        wait_empty();

        // Continuous at rate 2, then abort mid-conversion
        issue_start(1'b1, 2, 2, "R4", t);
        rate_i = 2'd3;
        wait_empty();
        wait_cyc(cyc + 1000);
        issue_start(1'b0, 3, 1, "R9", t);
        wait_empty();
        wait_cyc(t + 2 * SS[3] + 100);
        check(drdy_n_o == 1'b0, "R9", "drdy_n after abort run", int'(drdy_n_o), 0);

        // Abort inside the startup delay
        issue_start(1'b0, 3, 1, "R9", t);
        repeat (20) @(negedge clk);
        issue_start(1'b0, 3, 1, "R9", t);
        wait_empty();
        wait_cyc(t + 300);
        check(exp_q.size() == 0, "R9", "pending items at end", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (198000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule